// File: doc/BRIEF.md
# I2C Sensor Register Target with Bus-Lockup Timeout

This block is the serial-bus slave front end for a small light-sensor register bank. It samples the two bus lines with the system clock through a synchronizer and a glitch filter. From the filtered lines it recognises start and stop conditions, decodes a 7-bit device address with its read/write bit, and acknowledges by pulling SDA low through an open-drain enable. Once addressed, a host can set a register pointer and then write or read 16-bit registers. Data is sent high byte first.

The bank exposes a live sensor result from an input port, three writable registers (configuration, low threshold and high threshold), and two fixed identification words. A watchdog measures how long SCL stays low. When SCL has been low for the configured time, about 28 ms by default, the bus state machine returns to idle and releases SDA. A stuck host therefore cannot hold the bus.

Top module: `i2c_sensor_target`

## Requirements
- R1: After reset, SDA is released, the configuration output is C810h, the low limit is C000h and the high limit is BFFFh.
- R2: A start (SDA falling while SCL is high) begins address reception from any state, including in the middle of a transfer without a stop. A stop (SDA rising while SCL is high) returns the target to idle, and a write pair cut short by a stop changes no register.
- R3: An address byte whose upper seven bits (sent MSB first) equal DEV_ADDR (default 44h) is acknowledged on the ninth clock. Bit 0 of that byte selects read (1) or write (0). Any other address gets no acknowledge, and SDA stays released until the next start.
- R4: In a write, the first data byte loads the register pointer. Each following pair of bytes, high byte first, writes the whole 16-bit register at that pointer; later pairs write the same register again. Every byte is acknowledged.
- R5: A read returns the register at the last pointer value, high byte first. After each SCL falling edge the next bit is presented, and the target only starts pulling SDA low while SCL is low. A host acknowledge after the low byte repeats the same register. A host not-acknowledge releases SDA.
- R6: The readable map is 00h result input, 01h configuration, 02h low limit, 03h high limit, 7Eh fixed 5449h and 7Fh fixed 3001h. Any other offset reads 0000h.
- R7: Writes to 00h, 7Eh, 7Fh or any unmapped offset are acknowledged but change no register.
- R8: If filtered SCL stays low for (CLK_HZ/1e6)*TIMEOUT_US consecutive cycles, the target goes idle and releases SDA. It releases SDA no earlier than that, and a following transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| result_i | input | 16 | Live sensor result shown at offset 00h |
| sda_oe | output | 1 | When 1, pull SDA low (open drain) |
| cfg_o | output | 16 | Configuration register |
| lo_lim_o | output | 16 | Low threshold register |
| hi_lim_o | output | 16 | High threshold register |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except for deliberate start and stop conditions. Every line level is held for longer than the synchronizer plus the filter length. The host never drives SDA low while the target is sending data. The bench keeps to these rules by building every transfer from bit tasks with a quarter-period of ten clocks, releasing SDA for every target bit, and issuing a repeated start only after a target acknowledge has ended.

// File: rtl/i2c_sensor_target.sv
module i2c_sensor_target #(
  parameter logic [6:0]  DEV_ADDR   = 7'h44,
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned TIMEOUT_US = 28_000,
  parameter int unsigned FILT_LEN   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [15:0] result_i,
  output logic        sda_oe,
  output logic [15:0] cfg_o,
  output logic [15:0] lo_lim_o,
  output logic [15:0] hi_lim_o
);
  localparam int unsigned TO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int TW = $clog2(TO_CYC + 1);
  localparam int FW = $clog2(FILT_LEN + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_WR = 3'd3,
                         S_WACK = 3'd4, S_RD = 3'd5, S_RACK = 3'd6;

  logic [1:0] scl_s, sda_s;
  logic scl_f, sda_f, scl_p, sda_p;
  logic [FW-1:0] scl_fc, sda_fc;
  logic [TW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i}; sda_s <= {sda_s[0], sda_i};
      scl_p <= scl_f; sda_p <= sda_f;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_f <= 1'b1; scl_fc <= '0; end
    else if (scl_s[1] == scl_f) scl_fc <= '0;
    else if (scl_fc == FW'(FILT_LEN - 1)) begin scl_f <= scl_s[1]; scl_fc <= '0; end
    else scl_fc <= scl_fc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin sda_f <= 1'b1; sda_fc <= '0; end
    else if (sda_s[1] == sda_f) sda_fc <= '0;
    else if (sda_fc == FW'(FILT_LEN - 1)) begin sda_f <= sda_s[1]; sda_fc <= '0; end
    else sda_fc <= sda_fc + 1'b1;

  wire scl_rise = scl_f & ~scl_p;
  wire scl_fall = ~scl_f & scl_p;
  wire start_ev = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
  wire tmo      = ~scl_f & (lo_cnt == TW'(TO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lo_cnt <= '0;
    else if (scl_f) lo_cnt <= '0;
    else if (lo_cnt != TW'(TO_CYC)) lo_cnt <= lo_cnt + 1'b1;

  logic [2:0]  st;
  logic [3:0]  cnt;
  logic [7:0]  sh, ptr, hi_b;
  logic [15:0] tx, rd_val;
  logic [1:0]  bidx;
  logic        rw, rhalf, ack_ok;

  always_comb
    case (ptr)
      8'h00:   rd_val = result_i;
      8'h01:   rd_val = cfg_o;
      8'h02:   rd_val = lo_lim_o;
      8'h03:   rd_val = hi_lim_o;
      8'h7E:   rd_val = 16'h5449;
      8'h7F:   rd_val = 16'h3001;
      default: rd_val = 16'h0000;
    endcase

  wire byte_done = scl_fall & (cnt == 4'd8);
  wire wr_en = (st == S_WR) & byte_done & (bidx == 2'd2) & ~start_ev & ~stop_ev & ~tmo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_o <= 16'hC810; lo_lim_o <= 16'hC000; hi_lim_o <= 16'hBFFF;
    end else if (wr_en)
      case (ptr)
        8'h01: cfg_o    <= {hi_b, sh};
        8'h02: lo_lim_o <= {hi_b, sh};
        8'h03: hi_lim_o <= {hi_b, sh};
        default: ;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ptr <= '0; hi_b <= '0; tx <= '0;
      bidx <= '0; rw <= 1'b0; rhalf <= 1'b0; ack_ok <= 1'b0; sda_oe <= 1'b0;
    end else if (tmo || stop_ev) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (start_ev) begin
      st <= S_ADDR; cnt <= '0; bidx <= '0; sda_oe <= 1'b0;
    end else
      case (st)
        S_ADDR:
          if (scl_rise) begin sh <= {sh[6:0], sda_f}; cnt <= cnt + 1'b1; end
          else if (byte_done) begin
            if (sh[7:1] == DEV_ADDR) begin rw <= sh[0]; sda_oe <= 1'b1; st <= S_AACK; end
            else st <= S_IDLE;
          end
        S_AACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin tx <= rd_val; sda_oe <= ~rd_val[15]; rhalf <= 1'b0; st <= S_RD; end
            else begin sda_oe <= 1'b0; st <= S_WR; end
          end
        S_WR:
          if (scl_rise) begin sh <= {sh[6:0], sda_f}; cnt <= cnt + 1'b1; end
          else if (byte_done) begin
            sda_oe <= 1'b1; st <= S_WACK;
            case (bidx)
              2'd0:    begin ptr <= sh; bidx <= 2'd1; end
              2'd1:    begin hi_b <= sh; bidx <= 2'd2; end
              default: bidx <= 2'd1;
            endcase
          end
        S_WACK:
          if (scl_fall) begin sda_oe <= 1'b0; cnt <= '0; st <= S_WR; end
        S_RD:
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (scl_fall) begin
            tx <= tx << 1;
            if (cnt == 4'd8) begin sda_oe <= 1'b0; st <= S_RACK; end
            else sda_oe <= ~tx[14];
          end
        S_RACK:
          if (scl_rise) ack_ok <= ~sda_f;
          else if (scl_fall) begin
            cnt <= '0;
            if (ack_ok) begin
              st <= S_RD; rhalf <= ~rhalf;
              if (rhalf) begin tx <= rd_val; sda_oe <= ~rd_val[15]; end
              else sda_oe <= ~tx[15];
            end else st <= S_IDLE;
          end
        default: ;
      endcase
endmodule

// File: rtl/i2c_sensor_target_chk.sv
module i2c_sensor_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_f,
  input logic [2:0]  st,
  input logic        start_ev,
  input logic        stop_ev,
  input logic        tmo,
  input logic        wr_en,
  input logic [47:0] regs
);
  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> st == 3'd1);
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == 3'd0) && !sda_oe);
  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 |-> !sda_oe);
  p_drive_while_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  p_write_only_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(wr_en));
  p_timeout_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (st == 3'd0) && !sda_oe);
endmodule

bind i2c_sensor_target i2c_sensor_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f), .st(st),
  .start_ev(start_ev), .stop_ev(stop_ev), .tmo(tmo), .wr_en(wr_en),
  .regs({cfg_o, lo_lim_o, hi_lim_o})
);

// File: tb/i2c_sensor_target_tb.sv
module i2c_sensor_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int TO = 600;
  localparam logic [6:0] ADDR = 7'h44;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic [15:0] result_i = 16'h0000;
  logic sda_oe;
  logic [15:0] cfg_o, lo_lim_o, hi_lim_o;
  wire sda_bus = sda_h & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_cfg = 16'hC810, m_lo = 16'hC000, m_hi = 16'hBFFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_sensor_target #(.DEV_ADDR(ADDR), .CLK_HZ(1_000_000), .TIMEOUT_US(TO), .FILT_LEN(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .result_i(result_i),
    .sda_oe(sda_oe), .cfg_o(cfg_o), .lo_lim_o(lo_lim_o), .hi_lim_o(hi_lim_o));

  function automatic logic [15:0] exp_reg(input logic [7:0] p);
    case (p)
      8'h00: return result_i;
      8'h01: return m_cfg;
      8'h02: return m_lo;
      8'h03: return m_hi;
      8'h7E: return 16'h5449;
      8'h7F: return 16'h3001;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] p, input logic [15:0] d);
    case (p)
      8'h01: m_cfg = d;
      8'h02: m_lo = d;
      8'h03: m_hi = d;
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic i2c_stop();
    sda_h = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b1; wq(Q);
  endtask
  task automatic wbit(input logic b);
    sda_h = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask
  task automatic rbit(output logic b);
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a); ack = ~a;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~ack);
  endtask

  task automatic reg_write(input logic [7:0] p, input logic [15:0] d, output logic ok);
    logic a0, a1, a2, a3;
    i2c_start(); wbyte({ADDR, 1'b0}, a0); wbyte(p, a1); wbyte(d[15:8], a2); wbyte(d[7:0], a3);
    i2c_stop(); ok = a0 & a1 & a2 & a3; model_wr(p, d);
  endtask

  task automatic reg_read(input logic [7:0] p, output logic [15:0] d);
    logic a;
    i2c_start(); wbyte({ADDR, 1'b0}, a); wbyte(p, a);
    i2c_start(); wbyte({ADDR, 1'b1}, a);
    rbyte(d[15:8], 1'b1); rbyte(d[7:0], 1'b0); i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok, a;
    logic [15:0] d;
    logic [7:0] b0, b1, b2, b3;
    void'($urandom(32'h5EED1234));
    wq(5); rst_n = 1'b1; wq(5);

    chk("R1 sda released", sda_oe, 0);
    chk("R1 cfg reset", cfg_o, 16'hC810);
    chk("R1 low reset", lo_lim_o, 16'hC000);
    chk("R1 high reset", hi_lim_o, 16'hBFFF);

    reg_read(8'h7E, d); chk("R6 id 7E", d, 16'h5449);
    reg_read(8'h7F, d); chk("R6 id 7F", d, 16'h3001);
    reg_read(8'h01, d); chk("R1 R5 cfg read", d, 16'hC810);
    result_i = 16'hA55A;
    reg_read(8'h00, d); chk("R6 result read", d, 16'hA55A);
    reg_read(8'h40, d); chk("R6 unmapped read", d, 16'h0000);

    reg_write(8'h01, 16'h1234, ok);
    chk("R4 write acked", ok, 1); chk("R4 cfg_o", cfg_o, 16'h1234);
    reg_read(8'h01, d); chk("R4 readback", d, 16'h1234);

    reg_write(8'h7E, 16'hFFFF, ok);
    chk("R7 ro write acked", ok, 1);
    reg_read(8'h7E, d); chk("R7 ro unchanged", d, 16'h5449);
    reg_write(8'h00, 16'h0F0F, ok);
    chk("R7 regs unchanged", {cfg_o, lo_lim_o, hi_lim_o}, {m_cfg, m_lo, m_hi});

    // R3 wrong address
    i2c_start(); wbyte({ADDR ^ 7'h01, 1'b0}, a);
    chk("R3 no ack wrong addr", a, 0);
    wbyte(8'h00, a);
    chk("R3 stays released", {a, sda_oe}, 0);
    i2c_stop();

    // R4 multiple pairs to same register
    i2c_start(); wbyte({ADDR, 1'b0}, a); wbyte(8'h02, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); wbyte(8'h44, a);
    chk("R4 last byte acked", a, 1);
    i2c_stop(); m_lo = 16'h3344;
    chk("R4 second pair wins", lo_lim_o, 16'h3344);

    // R2 stop mid-pair changes nothing
    i2c_start(); wbyte({ADDR, 1'b0}, a); wbyte(8'h03, a); wbyte(8'h99, a); i2c_stop();
    chk("R2 partial pair ignored", hi_lim_o, 16'hBFFF);

    // R5 pointer-only write then read with last pointer, four bytes
    i2c_start(); wbyte({ADDR, 1'b0}, a); wbyte(8'h02, a); i2c_stop();
    i2c_start(); wbyte({ADDR, 1'b1}, a);
    chk("R3 read addr acked", a, 1);
    rbyte(b0, 1'b1); rbyte(b1, 1'b1); rbyte(b2, 1'b1); rbyte(b3, 1'b0);
    chk("R5 first pair", {b0, b1}, 16'h3344);
    chk("R5 repeat pair", {b2, b3}, 16'h3344);
    chk("R5 released after nack", sda_oe, 0);
    i2c_stop();

    // R8 timeout while target holds acknowledge
    i2c_start();
    for (int i = 7; i >= 0; i--) wbit(i == 0 ? 1'b0 : ADDR[i-1]);
    chk("R3 ack driven", sda_oe, 1);
    wq(TO - 100);
    chk("R8 not early", sda_oe, 1);
    wq(200);
    chk("R8 released after timeout", sda_oe, 0);
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    reg_read(8'h7F, d); chk("R8 recovery", d, 16'h3001);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] p;
      logic [15:0] v;
      case ($urandom % 7)
        0: p = 8'h00; 1: p = 8'h01; 2: p = 8'h02; 3: p = 8'h03;
        4: p = 8'h7E; 5: p = 8'h7F; default: p = 8'h04 + 8'($urandom % 8'h70);
      endcase
      v = 16'($urandom);
      result_i = 16'($urandom);
      if ($urandom % 2) begin
        reg_write(p, v, ok);
        chk("R4 R7 random ack", ok, 1);
        chk("R4 R7 random regs", {cfg_o, lo_lim_o, hi_lim_o}, {m_cfg, m_lo, m_hi});
      end else begin
        reg_read(p, d);
        chk("R5 R6 random read", d, exp_reg(p));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule